// File: doc/BRIEF.md
# Bridge Configuration Header Register File

This block holds the 64-byte configuration header of a type-1 (bridge) function in flip-flops. It serves one configuration access per cycle. Each access carries a byte address, a size of 1, 2 or 4 bytes, a write flag and write data. Every bit of each of the sixteen dwords has one attribute: read-only, read-write, write-one-to-clear, or reserved. That attribute decides what a read returns and how a write of part of a dword is merged into the stored word.

Three strap inputs reshape the attribute tables and are held steady while the block runs:

- One strap selects PCIe operation. It turns the legacy bits that only conventional PCI uses into reserved bits.
- One strap removes prefetchable-memory forwarding.
- One strap removes I/O forwarding.

Hardware error-status inputs can set the write-one-to-clear bits on any cycle.

Read data and the error flag are registered. Both appear on the cycle after the access.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset, the register contents are as follows. Dword 0 holds the identity parameter. Dword 1 holds 0x00100000 (the capability-list bit, bit 20, is set). Dword 2 holds 0x060400 in bits 31:8 and the revision parameter in bits 7:0. Dword 3 holds 0x00010010 (header type 0x01 in bits 23:16, cache line 0x10 in bits 7:0). Every other dword holds 0. `rdData` and `accErr` are 0.
- R2: A read selects the dword given by address bits 5:2. Reserved bits always read as 0.
- R3: Let k be address bits 1:0. A size-1 read returns bits [8k+7:8k] of the dword. A size-2 read returns up to 16 bits starting at bit 8k, zero-extended. A size-4 read returns the whole dword with no shift. The result appears on `rdData` one cycle after the access and stays there until the next valid read.
- R4: An access whose size is not 1, 2 or 4 pulses `accErr` high on the next cycle. Such an access changes no register and leaves `rdData` unchanged. Every other cycle, `accErr` is 0.
- R5: A write selects byte lanes. Size 4 selects all lanes with no shift. Size 2 selects 0xFFFF<<8k and size 1 selects 0xFF<<8k, with the data shifted by 8k. Read-write bits inside the lanes take the shifted data. All other bits keep their value.
- R6: A write-one-to-clear bit inside the written lanes clears when its data bit is 1. A data bit of 0 leaves it unchanged.
- R7: A write never changes a read-only bit. The write masks per dword are:
  - dword 1: read-write 0x00000147; write-one-to-clear 0xF9000000.
  - dword 6: read-write 0x00FFFFFF.
  - dword 7: read-write 0x0000F0F0; write-one-to-clear 0xF9000000.
  - dwords 8 and 9: read-write 0xFFF0FFF0.
  - dwords 10, 11 and 12: read-write 0xFFFFFFFF.
  - dword 15: read-write 0x0B6F00FF; write-one-to-clear 0x04000000.
  - dwords 0, 2, 3, 4, 5, 13 and 14: read-only.
- R8: `priErrSet[5:1]` sets dword 1 bits 31:27 and `priErrSet[0]` sets dword 1 bit 24. `secErrSet` sets the same positions in dword 7. `discardSet` sets dword 15 bit 26. A set in the same cycle as a clearing write wins.
- R9: With `optNoPref` high, dword 9 is fully read-only and reads 0 after reset.
- R10: With `optNoIo` high, the following bits become read-only: dword 1 bit 0, dword 7 bits 15:0, and all of dword 12.
- R11: With `pcieMode` high, the following bits become reserved: dword 6 bits 31:24, dword 15 bits 21, 24, 25, 27 and 23, and dword 15 bit 26. As a result, dword 15 then has read-write mask 0x004F00FF, and `discardSet` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcieMode | input | 1 | Strap: PCIe operation, legacy bits reserved |
| optNoPref | input | 1 | Strap: no prefetchable-memory forwarding |
| optNoIo | input | 1 | Strap: no I/O forwarding |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 6 | Byte address within the header |
| accSize | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| accWdata | input | 32 | Write data, right-aligned |
| priErrSet | input | 6 | Hardware sets for primary status error bits |
| secErrSet | input | 6 | Hardware sets for secondary status error bits |
| discardSet | input | 1 | Hardware set for bridge-control bit 26 |
| rdData | output | 32 | Registered read data |
| accErr | output | 1 | Registered illegal-size flag |

## Verification
A hardware status set and a software write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by raising `priErrSet[5]` during a byte write of 0xFF to address 0x07. It then reads the dword back and expects bit 31 to stay set while the other error bits in that lane clear. A behavioural model with its own per-field mask tables predicts `rdData` and `accErr` on every clock in all strap settings, so any masking or merge slip shows up on the cycle it happens.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int NUM_WORDS = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = $clog2(NUM_WORDS * 4);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int SET_W = 6;

  typedef struct packed {
    logic [DATA_W-1:0] ro;
    logic [DATA_W-1:0] rw;
    logic [DATA_W-1:0] w1c;
  } bitAttr_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic [IDX_W-1:0] wordIdx;
    logic [4:0] shift;
    logic [DATA_W-1:0] laneMask;
    logic [DATA_W-1:0] rdMask;
  } accStrobe_t;

  function automatic bitAttr_t attrOf(input int idx, input logic pcie,
                                      input logic noPref, input logic noIo);
    bitAttr_t a;
    a = '0;
    case (idx)
      0, 2, 4, 5, 14: a.ro = '1;
      1: begin
        a.rw  = 32'h0000_0147;
        a.ro  = 32'h06B0_02B8;
        a.w1c = 32'hF900_0000;
        if (pcie) a.ro &= ~32'h06A0_02B8;
        if (noIo) begin
          a.ro |= 32'h0000_0001;
          a.rw &= ~32'h0000_0001;
        end
      end
      3: begin
        a.ro = '1;
        if (pcie) a.ro &= ~32'h0000_FF00;
      end
      6: begin
        a.rw = 32'h00FF_FFFF;
        a.ro = pcie ? 32'h0 : 32'hFF00_0000;
      end
      7: begin
        a.rw  = 32'h0000_F0F0;
        a.ro  = pcie ? 32'h0000_0F0F : 32'h06A0_0F0F;
        a.w1c = 32'hF900_0000;
        if (noIo) begin
          a.ro |= 32'h0000_FFFF;
          a.rw &= ~32'h0000_FFFF;
        end
      end
      8: begin
        a.rw = 32'hFFF0_FFF0;
        a.ro = 32'h000F_000F;
      end
      9: begin
        a.rw = noPref ? 32'h0 : 32'hFFF0_FFF0;
        a.ro = noPref ? 32'hFFFF_FFFF : 32'h000F_000F;
      end
      10, 11: a.rw = '1;
      12: begin
        a.rw = noIo ? 32'h0 : 32'hFFFF_FFFF;
        a.ro = noIo ? 32'hFFFF_FFFF : 32'h0;
      end
      13: a.ro = 32'h0000_00FF;
      15: begin
        a.rw  = 32'h0B6F_00FF;
        a.ro  = 32'h0080_FF00;
        a.w1c = 32'h0400_0000;
        if (pcie) begin
          a.rw &= ~32'h0B20_0000;
          a.ro &= ~32'h0080_0000;
          a.w1c = 32'h0;
        end
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] resetWord(input int idx, input logic [31:0] idWord,
                                                  input logic [7:0] revId);
    case (idx)
      0: return idWord;
      1: return 32'h0010_0000;
      2: return {24'h060400, revId};
      3: return 32'h0001_0010;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] expandErr(input logic [SET_W-1:0] s);
    return {s[5:1], 2'b00, s[0], 24'h0};
  endfunction
endpackage

// File: rtl/bcr_ctrl.sv
module bcr_ctrl
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [2:0]        accSize,
  output accStrobe_t        strb,
  output logic              accErr
);
  logic sizeOk;
  logic [4:0] laneShift;

  always_comb begin
    sizeOk = (accSize == 3'd1) || (accSize == 3'd2) || (accSize == 3'd4);
    laneShift = (accSize == 3'd4) ? 5'd0 : {accAddr[1:0], 3'b000};
    strb.wrEn = accValid && accWrite && sizeOk;
    strb.rdEn = accValid && !accWrite && sizeOk;
    strb.wordIdx = accAddr[ADDR_W-1:2];
    strb.shift = laneShift;
    case (accSize)
      3'd1: begin
        strb.laneMask = 32'h0000_00FF << laneShift;
        strb.rdMask = 32'h0000_00FF;
      end
      3'd2: begin
        strb.laneMask = 32'h0000_FFFF << laneShift;
        strb.rdMask = 32'h0000_FFFF;
      end
      default: begin
        strb.laneMask = '1;
        strb.rdMask = '1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) accErr <= 1'b0;
    else accErr <= accValid && !sizeOk;
  end

  assert_bad_size_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSize != 3'd1 && accSize != 3'd2 && accSize != 3'd4) |=> accErr);

  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !accErr);
endmodule

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h0001_1D0F,
  parameter logic [7:0]  REV_ID  = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pcieMode,
  input  logic              optNoPref,
  input  logic              optNoIo,
  input  accStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SET_W-1:0]  priErrSet,
  input  logic [SET_W-1:0]  secErrSet,
  input  logic              discardSet,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] nxtWord [NUM_WORDS];
  logic [DATA_W-1:0] hwSet [NUM_WORDS];
  logic [DATA_W-1:0] visMask [NUM_WORDS];
  bitAttr_t attr [NUM_WORDS];
  logic [DATA_W-1:0] shData;

  assign shData = wrData << strb.shift;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    if (w == 1) begin : g_pri
      assign hwSet[w] = expandErr(priErrSet);
    end else if (w == 7) begin : g_sec
      assign hwSet[w] = expandErr(secErrSet);
    end else if (w == 15) begin : g_ctl
      assign hwSet[w] = {5'b0, discardSet, 26'b0};
    end else begin : g_none
      assign hwSet[w] = '0;
    end

    always_comb begin
      logic [DATA_W-1:0] rwHit;
      logic [DATA_W-1:0] clrHit;
      logic sel;
      attr[w] = attrOf(w, pcieMode, optNoPref, optNoIo);
      visMask[w] = attr[w].ro | attr[w].rw | attr[w].w1c;
      sel = strb.wrEn && (strb.wordIdx == IDX_W'(w));
      rwHit = sel ? (attr[w].rw & strb.laneMask) : '0;
      clrHit = sel ? (attr[w].w1c & strb.laneMask & shData) : '0;
      nxtWord[w] = ((words[w] & ~rwHit) | (shData & rwHit)) & ~clrHit;
      nxtWord[w] = nxtWord[w] | (hwSet[w] & attr[w].w1c);
    end

    always_ff @(posedge clk) begin
      if (!rstN) words[w] <= resetWord(w, ID_WORD, REV_ID);
      else words[w] <= nxtWord[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn)
      rdData <= ((words[strb.wordIdx] & visMask[strb.wordIdx]) >> strb.shift) & strb.rdMask;
  end

  logic [NUM_WORDS*DATA_W-1:0] flatState;
  always_comb
    for (int i = 0; i < NUM_WORDS; i++) flatState[i*DATA_W +: DATA_W] = words[i];

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    priErrSet[0] |=> words[1][24]);

  assert_discard_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (discardSet && !pcieMode) |=> words[15][26]);

  assert_ro_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(words[0]) && $stable(words[2]) && $stable(words[4])));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn && priErrSet == '0 && secErrSet == '0 && !discardSet) |=> $stable(flatState));

  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));

  assert_pcie_reserved_R11: assert property (@(posedge clk) disable iff (!rstN)
    pcieMode |-> (!words[15][26] && words[6][31:24] == 8'h00));
endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bcr_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h0001_1D0F,
  parameter logic [7:0]  REV_ID  = 8'h02
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pcieMode,
  input  logic        optNoPref,
  input  logic        optNoIo,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [5:0]  accAddr,
  input  logic [2:0]  accSize,
  input  logic [31:0] accWdata,
  input  logic [5:0]  priErrSet,
  input  logic [5:0]  secErrSet,
  input  logic        discardSet,
  output logic [31:0] rdData,
  output logic        accErr
);
  accStrobe_t strb;

  bcr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accSize(accSize), .strb(strb), .accErr(accErr)
  );

  bcr_datapath #(.ID_WORD(ID_WORD), .REV_ID(REV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .pcieMode(pcieMode), .optNoPref(optNoPref),
    .optNoIo(optNoIo), .strb(strb), .wrData(accWdata), .priErrSet(priErrSet),
    .secErrSet(secErrSet), .discardSet(discardSet), .rdData(rdData)
  );
endmodule

// File: tb/bridge_cfg_regs_bench.sv
module bridge_cfg_regs_bench;
  logic clk = 0;
  logic rstN = 0;
  logic pcieMode = 0, optNoPref = 0, optNoIo = 0;
  logic accValid = 0, accWrite = 0;
  logic [5:0] accAddr = 0;
  logic [2:0] accSize = 4;
  logic [31:0] accWdata = 0;
  logic [5:0] priErrSet = 0, secErrSet = 0;
  logic discardSet = 0;
  logic [31:0] rdData;
  logic accErr;

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  bridge_cfg_regs u_bridge_cfg_regs (
    .clk(clk), .rstN(rstN), .pcieMode(pcieMode), .optNoPref(optNoPref), .optNoIo(optNoIo),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr), .accSize(accSize),
    .accWdata(accWdata), .priErrSet(priErrSet), .secErrSet(secErrSet),
    .discardSet(discardSet), .rdData(rdData), .accErr(accErr)
  );

  // Behavioural reference: per-field masks built from the requirement text
  logic [31:0] mdl [16];
  logic [31:0] expRd;
  logic expErr;

  function automatic logic [31:0] fld(input int hi, input int lo);
    logic [31:0] m = 0;
    for (int b = lo; b <= hi; b++) m[b] = 1'b1;
    return m;
  endfunction

  task automatic masksFor(input int i, output logic [31:0] rw, output logic [31:0] w1c,
                          output logic [31:0] vis);
    logic [31:0] errBits;
    errBits = fld(31, 27) | fld(24, 24);
    rw = 0; w1c = 0; vis = 0;
    case (i)
      1: begin
        rw = fld(0, 0) | fld(1, 1) | fld(2, 2) | fld(6, 6) | fld(8, 8);
        if (optNoIo) rw[0] = 0;
        w1c = errBits;
        vis = rw | w1c | fld(20, 20) | fld(0, 0);
        if (!pcieMode) vis |= 32'h06A0_02B8;
      end
      3: vis = pcieMode ? ~fld(15, 8) : '1;
      6: begin rw = fld(23, 0); vis = pcieMode ? rw : '1; end
      7: begin
        rw = optNoIo ? 0 : (fld(15, 12) | fld(7, 4));
        w1c = errBits;
        vis = fld(15, 0) | w1c | (pcieMode ? 32'h0 : 32'h06A0_0000);
      end
      8: begin rw = fld(31, 20) | fld(15, 4); vis = '1; end
      9: begin rw = optNoPref ? 0 : (fld(31, 20) | fld(15, 4)); vis = '1; end
      10, 11: begin rw = '1; vis = '1; end
      12: begin rw = optNoIo ? 0 : '1; vis = '1; end
      13: vis = fld(7, 0);
      15: begin
        rw = fld(7, 0) | fld(16, 16) | fld(17, 17) | fld(18, 18) | fld(19, 19) | fld(22, 22);
        if (!pcieMode) rw |= fld(21, 21) | fld(24, 24) | fld(25, 25) | fld(27, 27);
        w1c = pcieMode ? 0 : fld(26, 26);
        vis = rw | w1c | fld(15, 8) | (pcieMode ? 32'h0 : fld(23, 23));
      end
      default: vis = '1;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mdl[i] = 0;
      mdl[0] = 32'h0001_1D0F;
      mdl[1] = 32'h0010_0000;
      mdl[2] = 32'h0604_0002;
      mdl[3] = 32'h0001_0010;
      expRd <= 0;
      expErr <= 0;
    end else begin
      logic [31:0] rw, w1c, vis, lane, sd;
      int idx, sh;
      bit ok;
      ok = (accSize == 1) || (accSize == 2) || (accSize == 4);
      expErr <= accValid && !ok;
      idx = accAddr / 4;
      sh = (accSize == 4) ? 0 : (accAddr % 4) * 8;
      masksFor(idx, rw, w1c, vis);
      if (accValid && ok && !accWrite) begin
        if (accSize == 1) expRd <= ((mdl[idx] & vis) >> sh) & 32'hFF;
        else if (accSize == 2) expRd <= ((mdl[idx] & vis) >> sh) & 32'hFFFF;
        else expRd <= mdl[idx] & vis;
      end
      if (accValid && ok && accWrite) begin
        lane = (accSize == 4) ? '1 : ((accSize == 2) ? (32'hFFFF << sh) : (32'hFF << sh));
        sd = accWdata << sh;
        mdl[idx] = (mdl[idx] & ~(rw & lane)) | (sd & rw & lane);
        mdl[idx] = mdl[idx] & ~(w1c & lane & sd);
      end
      masksFor(1, rw, w1c, vis);
      mdl[1] |= {priErrSet[5:1], 2'b0, priErrSet[0], 24'h0} & w1c;
      masksFor(7, rw, w1c, vis);
      mdl[7] |= {secErrSet[5:1], 2'b0, secErrSet[0], 24'h0} & w1c;
      masksFor(15, rw, w1c, vis);
      mdl[15] |= {5'b0, discardSet, 26'b0} & w1c;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check({curReq, " rdData"}, rdData, expRd);
      check({curReq, " accErr"}, {31'b0, accErr}, {31'b0, expErr});
    end
  end

  task automatic acc(input bit wr, input logic [5:0] a, input logic [2:0] s, input logic [31:0] d);
    accValid = 1; accWrite = wr; accAddr = a; accSize = s; accWdata = d;
    @(negedge clk);
    accValid = 0; accWrite = 0;
  endtask

  task automatic readExpect(input logic [5:0] a, input logic [2:0] s, input logic [31:0] exp,
                            input string req);
    acc(0, a, s, 0);
    check(req, rdData, exp);
  endtask

  task automatic doReset(input bit pc, input bit np, input bit ni);
    rstN = 0;
    pcieMode = pc; optNoPref = np; optNoIo = ni;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  bit timedOut = 0;

  initial begin
    fork
      begin
        @(negedge clk);
        check("R1 reset rdData", rdData, 0);
        check("R1 reset accErr", {31'b0, accErr}, 0);
        doReset(0, 0, 0);
        curReq = "R1";
        readExpect(6'h00, 4, 32'h0001_1D0F, "R1 id");
        readExpect(6'h08, 4, 32'h0604_0002, "R1 class");
        readExpect(6'h0E, 1, 32'h01, "R1 header type");
        readExpect(6'h0C, 1, 32'h10, "R1 cache line");
        readExpect(6'h06, 2, 32'h0010, "R1 status");
        curReq = "R2";
        for (int i = 0; i < 16; i++) acc(1, 6'(i * 4), 4, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) acc(0, 6'(i * 4), 4, 0);
        readExpect(6'h04, 4, 32'h0010_0147, "R5 command");
        readExpect(6'h18, 4, 32'h00FF_FFFF, "R7 bus dword");
        readExpect(6'h3C, 4, 32'h0B6F_00FF, "R7 bridge ctl");
        readExpect(6'h34, 4, 32'h0, "R2 cap ptr");
        curReq = "R3";
        acc(1, 6'h18, 4, 32'h0033_2211);
        readExpect(6'h19, 1, 32'h22, "R3 byte lane1");
        readExpect(6'h1A, 2, 32'h0033, "R3 half lane2");
        readExpect(6'h1B, 1, 32'h00, "R3 byte lane3");
        readExpect(6'h19, 2, 32'h3322, "R3 half lane1");
        curReq = "R5";
        acc(1, 6'h1A, 1, 32'h77);
        readExpect(6'h18, 4, 32'h0077_2211, "R5 byte write");
        acc(1, 6'h19, 2, 32'hAAAA);
        readExpect(6'h18, 4, 32'h00AA_AA11, "R5 half write");
        curReq = "R4";
        acc(1, 6'h18, 3, 32'hFFFF_FFFF);
        check("R4 err flag", {31'b0, accErr}, 1);
        acc(0, 6'h00, 0, 0);
        check("R4 err read", {31'b0, accErr}, 1);
        check("R4 rdData held", rdData, 32'h00AA_AA11);
        readExpect(6'h18, 4, 32'h00AA_AA11, "R4 no change");
        curReq = "R8";
        priErrSet = 6'h3F; @(negedge clk); priErrSet = 0;
        readExpect(6'h04, 4, 32'hF910_0147, "R8 set");
        curReq = "R6";
        acc(1, 6'h07, 1, 32'h08);
        readExpect(6'h04, 4, 32'hF110_0147, "R6 clear one");
        curReq = "R8";
        priErrSet = 6'h20;
        acc(1, 6'h07, 1, 32'hFF);
        priErrSet = 0;
        readExpect(6'h04, 4, 32'h8010_0147, "R8 set wins");
        curReq = "R6";
        acc(1, 6'h04, 4, 32'h0);
        readExpect(6'h04, 4, 32'h8010_0000, "R6 zero keeps");
        curReq = "R8";
        secErrSet = 6'h01; @(negedge clk); secErrSet = 0;
        readExpect(6'h1C, 4, 32'h0100_F0F0, "R8 secondary");
        discardSet = 1; @(negedge clk); discardSet = 0;
        readExpect(6'h3E, 2, 32'h0F6F, "R8 discard");
        curReq = "R9";
        doReset(0, 1, 0);
        acc(1, 6'h24, 4, 32'hFFFF_FFFF);
        readExpect(6'h24, 4, 32'h0, "R9 pref locked");
        acc(1, 6'h20, 4, 32'hFFFF_FFFF);
        readExpect(6'h20, 4, 32'hFFF0_FFF0, "R9 mem open");
        curReq = "R10";
        doReset(0, 0, 1);
        acc(1, 6'h04, 4, 32'hFFFF_FFFF);
        readExpect(6'h04, 4, 32'h0010_0146, "R10 io enable");
        acc(1, 6'h1C, 4, 32'hFFFF_FFFF);
        readExpect(6'h1C, 4, 32'h0, "R10 io base");
        acc(1, 6'h30, 4, 32'hFFFF_FFFF);
        readExpect(6'h30, 4, 32'h0, "R10 io upper");
        curReq = "R11";
        doReset(1, 0, 0);
        acc(1, 6'h3C, 4, 32'hFFFF_FFFF);
        readExpect(6'h3C, 4, 32'h004F_00FF, "R11 bridge ctl");
        discardSet = 1; @(negedge clk); discardSet = 0;
        readExpect(6'h3C, 4, 32'h004F_00FF, "R11 discard ignored");
        acc(1, 6'h18, 4, 32'hFFFF_FFFF);
        readExpect(6'h18, 4, 32'h00FF_FFFF, "R11 latency");
        repeat (4) @(negedge clk);
      end
      begin
        repeat (200000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    if (timedOut) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule